// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block is the command front end of a parallel NOR-style flash model. It watches host write cycles made of an address, a data word and a write strobe, and turns one- and two-cycle command sequences into start pulses for the write state machine (WSM). Each start pulse comes with an operation code, a latched address, latched data and, for buffered writes, the word count and the buffer contents. The decoder refuses programs aimed at locked blocks. It also refuses malformed sequences. Both refusals are flagged as sticky status bits.

A buffered write has four parts. It opens with its setup code, then a count argument N, then exactly N+1 data writes, then a mandatory confirm code. Nothing starts before the confirm arrives, and any other value in the confirm slot throws away the whole sequence. While the WSM is busy, the decoder ignores every write except a suspend request. A suspend request is honoured only when a single program or a buffered write is running. During the busy period, the status word drives only its ready bit.

Top module: `flash_cui`

## Requirements
- R1: After reset no operation is pending, `wsm_start` and `wsm_suspend` are low, `stat_data` reads 0x0080 and `stat_oe` reads 0x00FF.
- R2: A write of 0x40 or 0x10, followed by a second write, gives one single-cycle `wsm_start` with `wsm_op` 0. The pulse appears two clocks after the strobe of the second write rises. `wsm_addr` and `wsm_data` carry that second write's address and data. In byte mode (`word_mode` low) the data bits above 7 read as zero.
- R3: A write of 0xE8, then a count N, then N+1 data writes, then 0xD0 gives `wsm_op` 1. `wsm_addr` is the address of the first data write and `wsm_count` is N. Buffer slot i (bits i*16 and up of `wsm_buf`) holds data write i. No start occurs before the 0xD0 write.
- R4: A count above 15 in word mode, or above 31 in byte mode, sets status bit 5, ends the sequence with no start, and leaves the decoder idle so that the next write is decoded as a command.
- R5: Any value other than 0xD0 in the confirm slot of a buffered write aborts the sequence. It sets status bit 5, gives no start, and leaves the decoder idle.
- R6: 0x60 followed by 0xD0 gives a start with `wsm_op` 2, which clears every lock bit. 0x60 followed by any other value sets status bit 5 and gives no start.
- R7: 0xC0 followed by a write gives a start with `wsm_op` 3 that carries that write's address and data, even when the target block is locked.
- R8: A program or buffered write whose block is locked gives no start and sets status bit 4. The block is the top log2(NBLK) bits of the address, and it is looked up in `lock_vec`. For a buffered write the address checked is the first data address.
- R9: In word mode, bits 15:8 of a command write are ignored, so 0x5510 acts as the program setup code.
- R10: While `wsm_busy` is high, `stat_oe` is 0x0080 and `stat_data` is all zero. While it is low, `stat_oe` is 0x00FF, bit 7 is 1, bit 5 is the sequence error and bit 4 is the program error. Both error bits are sticky until reset.
- R11: A write of 0xB0 while busy gives a one-cycle `wsm_suspend`, but only when the running operation was started as a program or a buffered write. After a lock clear or a protection program the same write gives nothing.
- R12: An unrecognised first-cycle code gives no start, sets no error bit and leaves the decoder idle.
- R13: While busy, every write other than an honoured suspend is ignored: no start, no status change, and no effect on sequence state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| word_mode | input | 1 | 1 = 16-bit bus, 0 = 8-bit bus |
| host_we | input | 1 | Host write strobe, captured on its rising edge |
| host_addr | input | ADDR_W | Host write address |
| host_data | input | DATA_W | Host write data |
| lock_vec | input | NBLK | One lock bit per block |
| wsm_busy | input | 1 | WSM operation in progress |
| wsm_start | output | 1 | One-cycle operation start |
| wsm_op | output | 2 | 0 program, 1 buffered write, 2 clear locks, 3 protection program |
| wsm_addr | output | ADDR_W | Target address of the started operation |
| wsm_data | output | DATA_W | Data of a single program or protection program |
| wsm_count | output | log2(BUF_DEPTH) | Buffered write count argument N |
| wsm_buf | output | BUF_DEPTH*DATA_W | Buffer slots, slot i at bits i*DATA_W and up |
| wsm_suspend | output | 1 | One-cycle suspend request |
| stat_data | output | DATA_W | Status word |
| stat_oe | output | DATA_W | Per-bit drive mask for the status word |

## Verification
The checker verifies on every cycle that start and suspend pulses last one cycle and that no start follows a busy cycle. It also verifies that the busy and idle status masks hold, that a buffered write never starts with a count outside the current mode's range, and that the error bits never drop while idle. Other behaviour can only be shown by the bench's scenarios against its reference model. Those scenarios cover correct latching of address, data and buffer slots, abort at the confirm slot, refusal of locked targets, the alternate setup code, the ignored upper command byte, and the suspend rule that depends on which operation is running.

// File: rtl/flash_cui_pkg.sv
`timescale 1ns/1ps
// Package: command codes, operation codes, sequence states and status bit
// positions shared by the decoder modules. Assumes 8-bit command codes.
package flash_cui_pkg;
    localparam logic [7:0] CMD_PROG_A  = 8'h40;
    localparam logic [7:0] CMD_PROG_B  = 8'h10;
    localparam logic [7:0] CMD_BUF     = 8'hE8;
    localparam logic [7:0] CMD_CLRLK   = 8'h60;
    localparam logic [7:0] CMD_PROT    = 8'hC0;
    localparam logic [7:0] CMD_CONFIRM = 8'hD0;
    localparam logic [7:0] CMD_SUSPEND = 8'hB0;

    typedef enum logic [1:0] {
        OP_PROG  = 2'd0,
        OP_BUF   = 2'd1,
        OP_CLRLK = 2'd2,
        OP_PROT  = 2'd3
    } op_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_PROG,
        S_BCNT,
        S_BDATA,
        S_BCONF,
        S_CLR,
        S_PROT
    } seq_e;

    localparam int ST_READY  = 7;
    localparam int ST_SEQERR = 5;
    localparam int ST_PRGERR = 4;
endpackage

// File: rtl/flash_cui_capture.sv
`timescale 1ns/1ps
// Strobe capture: finds the rising edge of the host write strobe and
// registers address and data at that point, then raises cap_vld for one
// cycle. In byte mode the data bits above the low byte are zeroed.
// Assumes the strobe is already synchronous to clk.
module flash_cui_capture #(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              word_mode,
    input  logic              host_we,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [DATA_W-1:0] host_data,
    output logic              cap_vld,
    output logic [ADDR_W-1:0] cap_addr,
    output logic [DATA_W-1:0] cap_data
);
    localparam int HI_W = DATA_W - 8;

    logic we_q;
    logic rise;

    assign rise = host_we & ~we_q;

    // Remember the previous strobe level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) we_q <= 1'b0;
        else        we_q <= host_we;
    end

    // Latch address and bus-width-adjusted data on the strobe edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_vld  <= 1'b0;
            cap_addr <= '0;
            cap_data <= '0;
        end else begin
            cap_vld <= rise;
            if (rise) begin
                cap_addr <= host_addr;
                cap_data <= word_mode ? host_data : {{HI_W{1'b0}}, host_data[7:0]};
            end
        end
    end
endmodule

// File: rtl/flash_cui_wbuf.sv
`timescale 1ns/1ps
// Write buffer: DEPTH slots filled in order from slot 0. clr rewinds the
// fill pointer; wr stores wdata at the pointer and advances it. Assumes the
// sequencer never writes more than DEPTH words between clears.
module flash_cui_wbuf #(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 32
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clr,
    input  logic                    wr,
    input  logic [DATA_W-1:0]       wdata,
    output logic [DEPTH*DATA_W-1:0] buf_flat
);
    localparam int IDX_W = $clog2(DEPTH);

    logic [IDX_W-1:0] idx;

    // Fill pointer: rewinds on clear, steps on every stored word.
    always_ff @(posedge clk) begin
        if (!rst_n)   idx <= '0;
        else if (clr) idx <= '0;
        else if (wr)  idx <= idx + 1'b1;
    end

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        logic [DATA_W-1:0] slot;
        // Slot g takes the data word when the pointer selects it.
        always_ff @(posedge clk) begin
            if (!rst_n)                        slot <= '0;
            else if (wr && idx == IDX_W'(g))   slot <= wdata;
        end
        assign buf_flat[g*DATA_W +: DATA_W] = slot;
    end
endmodule

// File: rtl/flash_cui_lockchk.sv
`timescale 1ns/1ps
// Lock lookup: returns the lock bit of the addressed block. Assumes NBLK is
// a power of two so that every block index is in range.
module flash_cui_lockchk #(
    parameter int NBLK  = 8,
    parameter int BLK_W = 3
) (
    input  logic [NBLK-1:0]  lock_vec,
    input  logic [BLK_W-1:0] blk,
    output logic             locked
);
    assign locked = lock_vec[blk];
endmodule

// File: rtl/flash_cui_seq.sv
`timescale 1ns/1ps
// Sequencer: decodes captured host writes into command sequences. It counts
// the buffered write data phase, checks the confirm slot and lock state, and
// issues start and suspend pulses. While the WSM is busy only a suspend
// request is acted on. Assumes cap_vld is a one-cycle pulse.
module flash_cui_seq
    import flash_cui_pkg::*;
#(
    parameter int ADDR_W   = 12,
    parameter int DATA_W   = 16,
    parameter int CNT_W    = 5,
    parameter int MAX_WORD = 15,
    parameter int MAX_BYTE = 31
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              word_mode,
    input  logic              cap_vld,
    input  logic [ADDR_W-1:0] cap_addr,
    input  logic [DATA_W-1:0] cap_data,
    input  logic              wsm_busy,
    input  logic              tgt_locked,
    output logic [ADDR_W-1:0] chk_addr,
    output logic              buf_clr,
    output logic              buf_wr,
    output logic              wsm_start,
    output logic [1:0]        wsm_op,
    output logic [ADDR_W-1:0] wsm_addr,
    output logic [DATA_W-1:0] wsm_data,
    output logic [CNT_W-1:0]  wsm_count,
    output logic              wsm_suspend,
    output logic              seq_err,
    output logic              prg_err
);
    seq_e              state;
    logic [7:0]        code;
    logic [CNT_W-1:0]  rem;
    logic              first;
    logic [ADDR_W-1:0] base_addr;
    logic              busy_q;
    logic              active;
    logic              take;
    int                lim;

    assign code = cap_data[7:0];
    assign take = cap_vld && !wsm_busy;
    assign lim  = word_mode ? MAX_WORD : MAX_BYTE;

    // Lock lookup address: the first data address at the confirm slot.
    always_comb begin
        chk_addr = (state == S_BCONF) ? base_addr : cap_addr;
    end

    // Buffer control: rewind on count, store during the data phase.
    always_comb begin
        buf_clr = take && (state == S_BCNT);
        buf_wr  = take && (state == S_BDATA);
    end

    // Main sequence tracker with start, suspend and error generation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state       <= S_IDLE;
            rem         <= '0;
            first       <= 1'b0;
            base_addr   <= '0;
            busy_q      <= 1'b0;
            active      <= 1'b0;
            wsm_start   <= 1'b0;
            wsm_op      <= 2'd0;
            wsm_addr    <= '0;
            wsm_data    <= '0;
            wsm_count   <= '0;
            wsm_suspend <= 1'b0;
            seq_err     <= 1'b0;
            prg_err     <= 1'b0;
        end else begin
            wsm_start   <= 1'b0;
            wsm_suspend <= 1'b0;
            busy_q      <= wsm_busy;
            if (busy_q && !wsm_busy) active <= 1'b0;
            if (cap_vld && wsm_busy) begin
                if (code == CMD_SUSPEND && active) wsm_suspend <= 1'b1;
            end else if (take) begin
                unique case (state)
                    S_IDLE: begin
                        if (code == CMD_PROG_A || code == CMD_PROG_B) state <= S_PROG;
                        else if (code == CMD_BUF)                     state <= S_BCNT;
                        else if (code == CMD_CLRLK)                   state <= S_CLR;
                        else if (code == CMD_PROT)                    state <= S_PROT;
                    end
                    S_PROG: begin
                        if (tgt_locked) begin
                            prg_err <= 1'b1;
                        end else begin
                            wsm_start <= 1'b1;
                            wsm_op    <= OP_PROG;
                            wsm_addr  <= cap_addr;
                            wsm_data  <= cap_data;
                            active    <= 1'b1;
                        end
                        state <= S_IDLE;
                    end
                    S_BCNT: begin
                        if (int'(code) > lim) begin
                            seq_err <= 1'b1;
                            state   <= S_IDLE;
                        end else begin
                            wsm_count <= code[CNT_W-1:0];
                            rem       <= code[CNT_W-1:0];
                            first     <= 1'b1;
                            state     <= S_BDATA;
                        end
                    end
                    S_BDATA: begin
                        if (first) begin
                            base_addr <= cap_addr;
                            first     <= 1'b0;
                        end
                        if (rem == '0) state <= S_BCONF;
                        else           rem   <= rem - 1'b1;
                    end
                    S_BCONF: begin
                        if (code != CMD_CONFIRM) begin
                            seq_err <= 1'b1;
                        end else if (tgt_locked) begin
                            prg_err <= 1'b1;
                        end else begin
                            wsm_start <= 1'b1;
                            wsm_op    <= OP_BUF;
                            wsm_addr  <= base_addr;
                            active    <= 1'b1;
                        end
                        state <= S_IDLE;
                    end
                    S_CLR: begin
                        if (code == CMD_CONFIRM) begin
                            wsm_start <= 1'b1;
                            wsm_op    <= OP_CLRLK;
                            active    <= 1'b0;
                        end else begin
                            seq_err <= 1'b1;
                        end
                        state <= S_IDLE;
                    end
                    S_PROT: begin
                        wsm_start <= 1'b1;
                        wsm_op    <= OP_PROT;
                        wsm_addr  <= cap_addr;
                        wsm_data  <= cap_data;
                        active    <= 1'b0;
                        state     <= S_IDLE;
                    end
                    default: state <= S_IDLE;
                endcase
            end
        end
    end
endmodule

// File: rtl/flash_cui.sv
`timescale 1ns/1ps
// Top of the flash command decoder. Chains strobe capture, sequencer, write
// buffer and lock lookup, and forms the status word and its drive mask.
// Assumes DATA_W is at least 8 and NBLK is a power of two.
module flash_cui
    import flash_cui_pkg::*;
#(
    parameter int ADDR_W    = 12,
    parameter int DATA_W    = 16,
    parameter int NBLK      = 8,
    parameter int BUF_DEPTH = 32
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        word_mode,
    input  logic                        host_we,
    input  logic [ADDR_W-1:0]           host_addr,
    input  logic [DATA_W-1:0]           host_data,
    input  logic [NBLK-1:0]             lock_vec,
    input  logic                        wsm_busy,
    output logic                        wsm_start,
    output logic [1:0]                  wsm_op,
    output logic [ADDR_W-1:0]           wsm_addr,
    output logic [DATA_W-1:0]           wsm_data,
    output logic [$clog2(BUF_DEPTH)-1:0] wsm_count,
    output logic [BUF_DEPTH*DATA_W-1:0] wsm_buf,
    output logic                        wsm_suspend,
    output logic [DATA_W-1:0]           stat_data,
    output logic [DATA_W-1:0]           stat_oe
);
    localparam int BLK_W    = $clog2(NBLK);
    localparam int CNT_W    = $clog2(BUF_DEPTH);
    localparam int MAX_BYTE = BUF_DEPTH - 1;
    localparam int MAX_WORD = BUF_DEPTH / 2 - 1;

    logic              cap_vld;
    logic [ADDR_W-1:0] cap_addr;
    logic [DATA_W-1:0] cap_data;
    logic [ADDR_W-1:0] chk_addr;
    logic              tgt_locked;
    logic              buf_clr;
    logic              buf_wr;
    logic              seq_err;
    logic              prg_err;

    flash_cui_capture #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_cap (
        .clk(clk), .rst_n(rst_n), .word_mode(word_mode), .host_we(host_we),
        .host_addr(host_addr), .host_data(host_data),
        .cap_vld(cap_vld), .cap_addr(cap_addr), .cap_data(cap_data)
    );

    flash_cui_lockchk #(.NBLK(NBLK), .BLK_W(BLK_W)) u_lock (
        .lock_vec(lock_vec), .blk(chk_addr[ADDR_W-1 -: BLK_W]), .locked(tgt_locked)
    );

    flash_cui_seq #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W),
        .MAX_WORD(MAX_WORD), .MAX_BYTE(MAX_BYTE)
    ) u_seq (
        .clk(clk), .rst_n(rst_n), .word_mode(word_mode),
        .cap_vld(cap_vld), .cap_addr(cap_addr), .cap_data(cap_data),
        .wsm_busy(wsm_busy), .tgt_locked(tgt_locked), .chk_addr(chk_addr),
        .buf_clr(buf_clr), .buf_wr(buf_wr),
        .wsm_start(wsm_start), .wsm_op(wsm_op), .wsm_addr(wsm_addr),
        .wsm_data(wsm_data), .wsm_count(wsm_count), .wsm_suspend(wsm_suspend),
        .seq_err(seq_err), .prg_err(prg_err)
    );

    flash_cui_wbuf #(.DATA_W(DATA_W), .DEPTH(BUF_DEPTH)) u_buf (
        .clk(clk), .rst_n(rst_n), .clr(buf_clr), .wr(buf_wr),
        .wdata(cap_data), .buf_flat(wsm_buf)
    );

    // Status word: only the ready bit is driven while the WSM is busy.
    always_comb begin
        stat_data = '0;
        stat_oe   = '0;
        if (wsm_busy) begin
            stat_oe[ST_READY] = 1'b1;
        end else begin
            stat_oe[7:0]         = 8'hFF;
            stat_data[ST_READY]  = 1'b1;
            stat_data[ST_SEQERR] = seq_err;
            stat_data[ST_PRGERR] = prg_err;
        end
    end
endmodule

// File: rtl/flash_cui_chk.sv
`timescale 1ns/1ps
// Checker: temporal properties of the decoder ports, bound into flash_cui.
module flash_cui_chk #(
    parameter int DATA_W = 16,
    parameter int CNT_W  = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              word_mode,
    input logic              wsm_busy,
    input logic              wsm_start,
    input logic [1:0]        wsm_op,
    input logic [CNT_W-1:0]  wsm_count,
    input logic              wsm_suspend,
    input logic [DATA_W-1:0] stat_data,
    input logic [DATA_W-1:0] stat_oe
);
    localparam int MAX_BYTE = (1 << CNT_W) - 1;
    localparam int MAX_WORD = (1 << CNT_W) / 2 - 1;
    localparam logic [DATA_W-1:0] BUSY_OE = DATA_W'(16'h0080);
    localparam logic [DATA_W-1:0] IDLE_OE = DATA_W'(16'h00FF);

    AST_START_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        wsm_start |=> !wsm_start); // R2
    AST_NO_START_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        $past(wsm_busy) |-> !wsm_start); // R13
    AST_BUSY_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        wsm_busy |-> (stat_oe == BUSY_OE) && !stat_data[7]); // R10
    AST_IDLE_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        !wsm_busy |-> (stat_oe == IDLE_OE) && stat_data[7]); // R10
    AST_COUNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (wsm_start && wsm_op == 2'd1) |-> (int'(wsm_count) <= (word_mode ? MAX_WORD : MAX_BYTE))); // R4
    AST_SUSPEND_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        wsm_suspend |=> !wsm_suspend); // R11
    AST_SUSPEND_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        wsm_suspend |-> $past(wsm_busy)); // R11
    AST_SEQERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(stat_data[5]) && $past(!wsm_busy) && !wsm_busy) |-> stat_data[5]); // R5
    AST_PRGERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(stat_data[4]) && $past(!wsm_busy) && !wsm_busy) |-> stat_data[4]); // R8
endmodule

bind flash_cui flash_cui_chk #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .word_mode(word_mode), .wsm_busy(wsm_busy),
    .wsm_start(wsm_start), .wsm_op(wsm_op), .wsm_count(wsm_count),
    .wsm_suspend(wsm_suspend), .stat_data(stat_data), .stat_oe(stat_oe)
);

// File: tb/flash_cui_test.sv
`timescale 1ns/1ps
// Bench: drives host write sequences, keeps a behavioural reference model
// and compares start, suspend and status outputs at every falling edge.
module flash_cui_test;
    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              word_mode = 1'b1;
    logic              host_we = 1'b0;
    logic [11:0]       host_addr = '0;
    logic [15:0]       host_data = '0;
    logic [7:0]        lock_vec = '0;
    logic              wsm_busy = 1'b0;
    logic              wsm_start;
    logic [1:0]        wsm_op;
    logic [11:0]       wsm_addr;
    logic [15:0]       wsm_data;
    logic [4:0]        wsm_count;
    logic [511:0]      wsm_buf;
    logic              wsm_suspend;
    logic [15:0]       stat_data;
    logic [15:0]       stat_oe;

    flash_cui uut (
        .clk(clk), .rst_n(rst_n), .word_mode(word_mode), .host_we(host_we),
        .host_addr(host_addr), .host_data(host_data), .lock_vec(lock_vec),
        .wsm_busy(wsm_busy), .wsm_start(wsm_start), .wsm_op(wsm_op),
        .wsm_addr(wsm_addr), .wsm_data(wsm_data), .wsm_count(wsm_count),
        .wsm_buf(wsm_buf), .wsm_suspend(wsm_suspend),
        .stat_data(stat_data), .stat_oe(stat_oe)
    );

    always #2 clk = ~clk;

    int    n_chk = 0;
    int    n_err = 0;
    string req = "R1";
    bit    done = 1'b0;
    bit    mon_on = 1'b0;

    // reference model state
    int          m_st;          // 0 idle,1 prog,2 count,3 data,4 confirm,5 clear,6 prot
    bit          m_busy, m_active, m_serr, m_perr;
    int          m_cnt;
    logic [11:0] m_base;
    logic [15:0] m_q[$];
    bit          e_start, e_susp;
    int          e_op, e_cnt;
    logic [11:0] e_addr;
    logic [15:0] e_data;
    logic [15:0] e_q[$];

    task automatic chk(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [15:0] exp_stat();
        if (m_busy) return 16'h0000;
        return 16'h0080 | (16'(m_serr) << 5) | (16'(m_perr) << 4);
    endfunction

    function automatic bit blk_locked(input logic [11:0] a);
        return lock_vec[a[11:9]];
    endfunction

    task automatic expect_start(input int op, input logic [11:0] a, input logic [15:0] d);
        e_start = 1'b1; e_op = op; e_addr = a; e_data = d;
    endtask

    // Behavioural model of one accepted host write.
    task automatic model_step(input logic [11:0] a, input logic [15:0] d);
        logic [7:0]  c  = d[7:0];
        logic [15:0] dm = word_mode ? d : {8'h00, d[7:0]};
        int          lim = word_mode ? 15 : 31;
        if (m_busy) begin
            if (c == 8'hB0 && m_active) e_susp = 1'b1;
            return;
        end
        case (m_st)
            0: begin
                if (c == 8'h40 || c == 8'h10) m_st = 1;
                else if (c == 8'hE8) m_st = 2;
                else if (c == 8'h60) m_st = 5;
                else if (c == 8'hC0) m_st = 6;
            end
            1: begin
                if (blk_locked(a)) m_perr = 1'b1;
                else begin expect_start(0, a, dm); m_active = 1'b1; end
                m_st = 0;
            end
            2: begin
                if (int'(c) > lim) begin m_serr = 1'b1; m_st = 0; end
                else begin m_cnt = int'(c); m_q.delete(); m_st = 3; end
            end
            3: begin
                if (m_q.size() == 0) m_base = a;
                m_q.push_back(dm);
                if (m_q.size() == m_cnt + 1) m_st = 4;
            end
            4: begin
                if (c != 8'hD0) m_serr = 1'b1;
                else if (blk_locked(m_base)) m_perr = 1'b1;
                else begin
                    expect_start(1, m_base, 16'h0);
                    e_cnt = m_cnt; e_q = m_q; m_active = 1'b1;
                end
                m_st = 0;
            end
            5: begin
                if (c == 8'hD0) begin expect_start(2, 12'h0, 16'h0); m_active = 1'b0; end
                else m_serr = 1'b1;
                m_st = 0;
            end
            default: begin
                expect_start(3, a, dm); m_active = 1'b0; m_st = 0;
            end
        endcase
    endtask

    // One host write: strobe high for one clock, then model update once the
    // sequencer has acted (two clocks after the strobe rise).
    task automatic wr(input logic [11:0] a, input logic [15:0] d);
        @(posedge clk); #1;
        host_we = 1'b1; host_addr = a; host_data = d;
        @(posedge clk); #1;
        host_we = 1'b0;
        @(posedge clk); #1;
        model_step(a, d);
    endtask

    task automatic set_busy(input bit v);
        @(posedge clk); #1;
        wsm_busy = v; m_busy = v;
        if (!v) m_active = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(posedge clk);
        #1;
    endtask

    task automatic do_reset(input bit wm);
        @(posedge clk); #1;
        mon_on = 1'b0; rst_n = 1'b0; host_we = 1'b0; wsm_busy = 1'b0; word_mode = wm;
        m_st = 0; m_busy = 0; m_active = 0; m_serr = 0; m_perr = 0;
        e_start = 0; e_susp = 0; m_q.delete(); e_q.delete();
        idle(3);
        rst_n = 1'b1; mon_on = 1'b1;
        // R1: reset state seen at the ports
        @(negedge clk);
        begin
            string keep = req;
            req = "R1";
            chk(wsm_start === 1'b0, "reset start", 32'(wsm_start), 0);
            chk(wsm_suspend === 1'b0, "reset suspend", 32'(wsm_suspend), 0);
            chk(stat_data === 16'h0080, "reset status", 32'(stat_data), 32'h80);
            chk(stat_oe === 16'h00FF, "reset oe", 32'(stat_oe), 32'hFF);
            req = keep;
        end
    endtask

    // Per-cycle comparison against the model.
    always @(negedge clk) begin
        if (rst_n && mon_on) begin
            chk(wsm_start === e_start, "start", 32'(wsm_start), 32'(e_start));
            if (e_start && wsm_start === 1'b1) begin
                chk(int'(wsm_op) == e_op, "op", 32'(wsm_op), 32'(e_op));
                if (e_op != 2) chk(wsm_addr === e_addr, "addr", 32'(wsm_addr), 32'(e_addr));
                if (e_op == 0 || e_op == 3) chk(wsm_data === e_data, "data", 32'(wsm_data), 32'(e_data));
                if (e_op == 1) begin
                    chk(int'(wsm_count) == e_cnt, "count", 32'(wsm_count), 32'(e_cnt));
                    for (int i = 0; i < e_q.size(); i++)
                        chk(wsm_buf[i*16 +: 16] === e_q[i], "buffer slot", 32'(wsm_buf[i*16 +: 16]), 32'(e_q[i]));
                end
            end
            chk(wsm_suspend === e_susp, "suspend", 32'(wsm_suspend), 32'(e_susp));
            chk(stat_data === exp_stat(), "status (R10)", 32'(stat_data), 32'(exp_stat()));
            chk(stat_oe === (m_busy ? 16'h0080 : 16'h00FF), "oe (R10)", 32'(stat_oe),
                32'(m_busy ? 16'h0080 : 16'h00FF));
            e_start = 1'b0;
            e_susp  = 1'b0;
        end
    end

    task automatic finish_run();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_err++;
            $display("FAIL watchdog: actual=running expected=finished");
            finish_run();
        end
    end

    initial begin
        // R1 reset, word mode
        do_reset(1'b1);

        // R2 program via 0x40, then busy with R10 mask, R11 suspend, R13 ignore
        req = "R2";
        wr(12'h100, 16'h0040);
        wr(12'h123, 16'hBEEF);
        set_busy(1'b1);
        req = "R10"; idle(3);
        req = "R11"; wr(12'h000, 16'h00B0);
        req = "R13"; wr(12'h000, 16'h0040); wr(12'h010, 16'h1234);
        set_busy(1'b0);
        wr(12'h200, 16'hBEEF); // idle: 0xEF is not a command

        // R9 upper command byte ignored, 0x10 setup accepted
        req = "R9";
        wr(12'h000, 16'h5510);
        wr(12'h0AA, 16'h1234);
        set_busy(1'b1); set_busy(1'b0);

        // R2 byte mode data masking
        req = "R2";
        @(posedge clk); #1; word_mode = 1'b0;
        wr(12'h000, 16'h0040);
        wr(12'h010, 16'hBEEF);
        set_busy(1'b1); set_busy(1'b0);

        // R3 buffered write, word mode, N=3, then R11 suspend while active
        do_reset(1'b1);
        req = "R3";
        wr(12'h000, 16'h00E8);
        wr(12'h000, 16'h0003);
        for (int i = 0; i < 4; i++) wr(12'h040 + 12'(i), 16'hA000 + 16'(i * 17));
        wr(12'h000, 16'h00D0);
        set_busy(1'b1);
        req = "R11"; wr(12'h000, 16'h00B0);
        set_busy(1'b0);

        // R3 buffered write, byte mode, largest count
        do_reset(1'b0);
        req = "R3";
        wr(12'h000, 16'h00E8);
        wr(12'h000, 16'h001F);
        for (int i = 0; i < 32; i++) wr(12'h300 + 12'(i), 16'h5500 + 16'(i * 7));
        wr(12'h000, 16'h00D0);

        // R4 count too large in word mode, then decoder idle
        do_reset(1'b1);
        req = "R4";
        wr(12'h000, 16'h00E8);
        wr(12'h000, 16'h0010);
        wr(12'h000, 16'h0040);
        wr(12'h044, 16'h7777);

        // R4 count too large in byte mode
        do_reset(1'b0);
        req = "R4";
        wr(12'h000, 16'h00E8);
        wr(12'h000, 16'h0020);

        // R5 wrong confirm aborts; later 0xD0 does nothing
        do_reset(1'b1);
        req = "R5";
        wr(12'h000, 16'h00E8);
        wr(12'h000, 16'h0001);
        wr(12'h050, 16'h1111);
        wr(12'h051, 16'h2222);
        wr(12'h000, 16'h00FF);
        wr(12'h000, 16'h00D0);

        // R6 lock clear, suspend refused after it (R11), bad confirm
        do_reset(1'b1);
        req = "R6";
        wr(12'h000, 16'h0060);
        wr(12'h000, 16'h00D0);
        set_busy(1'b1);
        req = "R11"; wr(12'h000, 16'h00B0);
        set_busy(1'b0);
        req = "R6";
        wr(12'h000, 16'h0060);
        wr(12'h000, 16'h0033);

        // R7 protection program ignores lock; R8 program to locked block
        do_reset(1'b1);
        lock_vec = 8'b0010_0000;
        req = "R7";
        wr(12'h000, 16'h00C0);
        wr(12'hA10, 16'h5A5A);
        set_busy(1'b1);
        req = "R11"; wr(12'h000, 16'h00B0);
        set_busy(1'b0);
        req = "R8";
        wr(12'h000, 16'h0040);
        wr(12'hA20, 16'h0001);

        // R8 buffered write to locked block
        do_reset(1'b1);
        req = "R8";
        wr(12'h000, 16'h00E8);
        wr(12'h000, 16'h0000);
        wr(12'hA00, 16'h0007);
        wr(12'h000, 16'h00D0);
        lock_vec = 8'h00;

        // R12 unknown first-cycle codes
        do_reset(1'b1);
        req = "R12";
        wr(12'h000, 16'h0077);
        wr(12'h000, 16'h1234);
        idle(2);

        finish_run();
    end
endmodule